// File: doc/BRIEF.md
# Column Zone Sparsifier

The block takes one 64-pixel slice of an active pixel column per clock as a hit vector, plus the column's address and a timestamp. It cuts the slice into eight vertical zones of eight pixels each and throws away every zone in which no pixel fired. Each remaining zone becomes a compact record made of the column address, the zone's 3-bit address within the slice and its 8-bit pixel pattern. All records from one column appear together on a wide output bus, in the low lanes and in ascending zone order, with a count of how many lanes are valid. A downstream buffer that can take from one to eight entries per write uses that count.

Hits arrive sorted by time. The timestamp therefore travels as a header flag and word on the first output beat of each run of beats that share a timestamp, and not in every record. A column with no hit at all is taken in and produces no output beat. A single output register stage, with a ready/valid handshake, stalls the input while the downstream side is not ready.

Top module: `zone_sparsifier`

## Requirements
- R1: After reset, `out_valid` and `out_ts_valid` are 0 and `in_ready` is 1.
- R2: A record is 18 bits: column address in bits 17:11, zone address in bits 10:8, pattern in bits 7:0. Zone z covers `in_hits[8z+7:8z]`, and bit k of its pattern is pixel 8z+k.
- R3: A zone whose 8 pixels are all zero produces no record. `out_count` equals the number of zones with at least one hit, from 1 to 8.
- R4: Records fill lanes 0 to `out_count`-1 in ascending zone order, with lane l at `out_recs[18l+17:18l]`. Every lane at or above `out_count` reads all zero.
- R5: An accepted column with no hit produces no output beat. `out_valid` is 0 in the next cycle and the block stays ready.
- R6: A column accepted at a clock edge (`in_valid` and `in_ready` high) is presented on the outputs right after that same edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and `in_ready` is 0, so no new column is taken.
- R8: `out_ts_valid` is 1, with `out_ts` equal to the column's timestamp, on the first output beat after reset. It is also 1 on any beat whose timestamp differs from that of the previous output beat. On every other beat it is 0.
- R9: With `out_ready` held high, a new column is accepted on every cycle and each one appears on the outputs one cycle after the previous column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Column slice present |
| in_ready | output | 1 | Block can take a column this cycle |
| in_col | input | 7 | Column address |
| in_hits | input | 64 | Pixel hit vector of the slice |
| in_ts | input | 8 | Timestamp of the column |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_count | output | 4 | Number of valid record lanes |
| out_recs | output | 144 | Eight 18-bit record lanes |
| out_ts_valid | output | 1 | Timestamp header attached to this beat |
| out_ts | output | 8 | Timestamp header value |

## Verification
Every result in this block is due exactly one clock edge after the column is accepted, because the only register between input and output is the output stage. Each scenario task drives its inputs on the falling edge, lets one rising edge pass and compares count, lanes and header a time step after that edge. The stall scenario instead samples at two further falling edges, to show that the beat and `in_ready` stay frozen, and it expects the waiting column one edge after `out_ready` rises. The header expectation is tracked in the bench from the sequence of timestamps of the non-empty beats.

// File: rtl/zs_pkg.sv
package zs_pkg;
   function automatic int unsigned zs_addr_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned zs_rec_bits(input int unsigned col_w,
                                                input int unsigned zones,
                                                input int unsigned zone_w);
      return col_w + zs_addr_bits(zones) + zone_w;
   endfunction
endpackage

// File: rtl/zs_zone_detect.sv
module zs_zone_detect #(
   parameter int unsigned ZONES  = 8,
   parameter int unsigned ZONE_W = 8
) (
   input  logic [ZONES*ZONE_W-1:0] hits,
   output logic [ZONES-1:0]        occupied
);
   for (genvar z = 0; z < ZONES; z++) begin : g_zone
      assign occupied[z] = |hits[z*ZONE_W +: ZONE_W];
   end
endmodule

// File: rtl/zs_packer.sv
module zs_packer
   import zs_pkg::*;
#(
   parameter int unsigned ZONES  = 8,
   parameter int unsigned ZONE_W = 8,
   parameter int unsigned COL_W  = 7,
   localparam int unsigned ZA_W  = zs_addr_bits(ZONES),
   localparam int unsigned REC_W = zs_rec_bits(COL_W, ZONES, ZONE_W),
   localparam int unsigned CNT_W = $clog2(ZONES + 1)
) (
   input  logic [COL_W-1:0]        col,
   input  logic [ZONES*ZONE_W-1:0] hits,
   input  logic [ZONES-1:0]        occupied,
   output logic [ZONES*REC_W-1:0]  recs,
   output logic [CNT_W-1:0]        count
);
   always_comb begin
      int unsigned lane;
      recs = '0;
      lane = 0;
      for (int unsigned z = 0; z < ZONES; z++) begin
         if (occupied[z]) begin
            recs[lane*REC_W +: REC_W] = {col, ZA_W'(z), hits[z*ZONE_W +: ZONE_W]};
            lane = lane + 1;
         end
      end
      count = CNT_W'(lane);
   end
endmodule

// File: rtl/zs_ts_tracker.sv
module zs_ts_tracker #(
   parameter int unsigned TS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [TS_W-1:0] ts,
   output logic            header
);
   logic            seen_q;
   logic [TS_W-1:0] last_q;

   assign header = !seen_q || (ts != last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (fire) begin
         seen_q <= 1'b1;
         last_q <= ts;
      end
   end

   // R8
   ts_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (seen_q && last_q == $past(ts)));
endmodule

// File: rtl/zone_sparsifier.sv
module zone_sparsifier
   import zs_pkg::*;
#(
   parameter int unsigned ZONES  = 8,
   parameter int unsigned ZONE_W = 8,
   parameter int unsigned COL_W  = 7,
   parameter int unsigned TS_W   = 8,
   localparam int unsigned ZA_W  = zs_addr_bits(ZONES),
   localparam int unsigned REC_W = zs_rec_bits(COL_W, ZONES, ZONE_W),
   localparam int unsigned CNT_W = $clog2(ZONES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [COL_W-1:0]        in_col,
   input  logic [ZONES*ZONE_W-1:0] in_hits,
   input  logic [TS_W-1:0]         in_ts,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [CNT_W-1:0]        out_count,
   output logic [ZONES*REC_W-1:0]  out_recs,
   output logic                    out_ts_valid,
   output logic [TS_W-1:0]         out_ts
);
   if (ZONES < 2) begin : g_bad_zones
      $error("zone_sparsifier: ZONES must be at least 2");
   end
   if (ZONE_W < 1 || COL_W < 1 || TS_W < 1) begin : g_bad_width
      $error("zone_sparsifier: widths must be nonzero");
   end

   logic [ZONES-1:0]       occupied;
   logic [ZONES*REC_W-1:0] packed_recs;
   logic [CNT_W-1:0]       packed_cnt;
   logic                   header;
   logic                   accept;
   logic                   fire;

   zs_zone_detect #(.ZONES(ZONES), .ZONE_W(ZONE_W)) i_detect (
      .hits(in_hits), .occupied(occupied));

   zs_packer #(.ZONES(ZONES), .ZONE_W(ZONE_W), .COL_W(COL_W)) i_packer (
      .col(in_col), .hits(in_hits), .occupied(occupied),
      .recs(packed_recs), .count(packed_cnt));

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;
   assign fire     = accept && (|occupied);

   zs_ts_tracker #(.TS_W(TS_W)) i_ts (
      .clk(clk), .rst_n(rst_n), .fire(fire), .ts(in_ts), .header(header));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_count    <= '0;
         out_recs     <= '0;
         out_ts_valid <= 1'b0;
         out_ts       <= '0;
      end else if (in_ready) begin
         out_valid <= fire;
         if (fire) begin
            out_count    <= packed_cnt;
            out_recs     <= packed_recs;
            out_ts_valid <= header;
            out_ts       <= in_ts;
         end else begin
            out_ts_valid <= 1'b0;
         end
      end
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_recs) &&
                                     $stable(out_count) && $stable(out_ts_valid)));
   // R7
   no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
   // R3
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count != 0 && out_count <= CNT_W'(ZONES)));
   // R5
   empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_hits == '0) |=> !out_valid);
   // R6
   next_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_hits != '0) |=> (out_valid && out_recs[REC_W-1 -: COL_W] == $past(in_col)));
   // R8
   ts_only_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ts_valid |-> out_valid);

   for (genvar l = 0; l < ZONES; l++) begin : g_lane_chk
      // R4
      lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_count <= CNT_W'(l)) |-> out_recs[l*REC_W +: REC_W] == '0);
      // R3
      lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_count > CNT_W'(l)) |-> out_recs[l*REC_W +: ZONE_W] != '0);
      if (l > 0) begin : g_order
         // R4
         lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_count > CNT_W'(l)) |->
               out_recs[l*REC_W+ZONE_W +: ZA_W] > out_recs[(l-1)*REC_W+ZONE_W +: ZA_W]);
      end
   end
endmodule

// File: tb/test_zone_sparsifier.sv
module test_zone_sparsifier;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [6:0]   in_col = '0;
   logic [63:0]  in_hits = '0;
   logic [7:0]   in_ts = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [3:0]   out_count;
   logic [143:0] out_recs;
   logic         out_ts_valid;
   logic [7:0]   out_ts;

   int n_chk = 0;
   int n_bad = 0;
   bit seen = 1'b0;
   logic [7:0] last_ts = '0;

   always #4 clk = ~clk;

   zone_sparsifier i_zone_sparsifier (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_col(in_col), .in_hits(in_hits), .in_ts(in_ts),
      .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
      .out_recs(out_recs), .out_ts_valid(out_ts_valid), .out_ts(out_ts));

   task automatic chk(input string req, input logic [143:0] act, input logic [143:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [143:0] exp_recs(input logic [6:0] col, input logic [63:0] h);
      logic [143:0] r = '0;
      int k = 0;
      for (int z = 0; z < 8; z++) begin
         if (h[z*8 +: 8] != 8'h00) begin
            r[k*18 +: 18] = {col, 3'(z), h[z*8 +: 8]};
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [3:0] exp_cnt(input logic [63:0] h);
      int k = 0;
      for (int z = 0; z < 8; z++) if (h[z*8 +: 8] != 8'h00) k++;
      return 4'(k);
   endfunction

   // drive on falling edge, accept at rising edge, compare one step later
   task automatic send_and_check(input string req, input logic [6:0] c,
                                 input logic [63:0] h, input logic [7:0] t);
      logic hdr;
      @(negedge clk);
      in_col = c; in_hits = h; in_ts = t; in_valid = 1'b1;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      if (h == '0) begin
         chk({req, " R5 no beat"}, 144'(out_valid), 144'(0));
         chk({req, " R5 still ready"}, 144'(in_ready), 144'(1));
      end else begin
         hdr = !seen || (t != last_ts);
         seen = 1'b1; last_ts = t;
         chk({req, " R6 valid"}, 144'(out_valid), 144'(1));
         chk({req, " R3 count"}, 144'(out_count), 144'(exp_cnt(h)));
         chk({req, " R2/R4 lanes"}, out_recs, exp_recs(c, h));
         chk({req, " R8 header"}, 144'(out_ts_valid), 144'(hdr));
         if (hdr) chk({req, " R8 ts"}, 144'(out_ts), 144'(t));
      end
   endtask

   task automatic t_reset;
      #1;
      chk("R1 out_valid", 144'(out_valid), 144'(0));
      chk("R1 ts_valid", 144'(out_ts_valid), 144'(0));
      chk("R1 in_ready", 144'(in_ready), 144'(1));
   endtask

   task automatic t_single;
      send_and_check("single", 7'd5, 64'h0000_00A5_0000_0000, 8'd10);
   endtask

   task automatic t_full;
      send_and_check("full", 7'd79, 64'h8040_2010_0804_0201, 8'd10);
   endtask

   task automatic t_sparse;
      send_and_check("sparse", 7'd42, 64'h8000_00FF_0000_3C00, 8'd11);
      send_and_check("lowzone", 7'd1, 64'h0000_0000_0000_0001, 8'd11);
   endtask

   task automatic t_empty;
      send_and_check("empty", 7'd3, 64'h0, 8'd12);
      send_and_check("after empty", 7'd4, 64'hFF00_0000_0000_0000, 8'd11);
   endtask

   task automatic t_stall;
      logic [63:0] ha = 64'h0000_1100_0000_2200;
      logic [63:0] hb = 64'h0700_0000_0000_0000;
      send_and_check("stall idle", 7'd0, 64'h0, 8'd20);
      out_ready = 1'b0;
      send_and_check("stall A", 7'd9, ha, 8'd20);
      @(negedge clk);
      in_col = 7'd10; in_hits = hb; in_ts = 8'd21; in_valid = 1'b1;
      #1;
      chk("R7 in_ready low", 144'(in_ready), 144'(0));
      @(negedge clk);
      @(negedge clk);
      chk("R7 lanes held", out_recs, exp_recs(7'd9, ha));
      chk("R7 count held", 144'(out_count), 144'(exp_cnt(ha)));
      chk("R7 valid held", 144'(out_valid), 144'(1));
      out_ready = 1'b1;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      seen = 1'b1; last_ts = 8'd21;
      chk("R7 B after release", out_recs, exp_recs(7'd10, hb));
      chk("R8 B header", 144'(out_ts_valid), 144'(1));
   endtask

   task automatic t_stream;
      send_and_check("R9 s0", 7'd60, 64'h0000_0000_00F0_000F, 8'd30);
      send_and_check("R9 s1", 7'd61, 64'h1000_0000_0000_0000, 8'd30);
      send_and_check("R9 s2", 7'd62, 64'h0101_0101_0101_0101, 8'd31);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_single;
      t_full;
      t_sparse;
      t_empty;
      t_stall;
      t_stream;
      @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule